// File: doc/BRIEF.md
# Serial Transmitter with Line Control

This block turns queued bytes into an asynchronous serial stream. Bytes arrive over a valid/ready write port into a 16-entry queue. A serializer takes them one at a time and sends each as a frame. A frame is a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit, and a stop period. The pace comes from an oversampling enable pulse, and every bit lasts 16 of those pulses. The baud divisor that produces the pulse belongs to a neighbouring block.

The line-control inputs set the character length, the parity mode, the stop period and a break override. The length, parity and stop settings are captured when a frame starts, so changing them in the middle of a frame has no effect on that frame. The break input pulls the line low at once. It does not change the frame timing underneath it. Two status outputs report when the queue is empty and when the whole transmitter is idle. A flush strobe empties the queue.

Back-pressure rules: a byte is accepted on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low exactly when the queue holds 16 bytes. A byte offered while `wr_ready` is low is not stored, so the writer must hold it or drop it. A byte offered in the same cycle as a flush is discarded.

Top module: `uart_tx_line`

## Requirements
- R1: Out of reset, and whenever no frame is in flight and break is off, `txd` is 1. After reset `hold_empty`, `tx_empty` and `wr_ready` are all 1.
- R2: A frame begins with a start bit of 0, followed by the data bits with bit 0 first. The number of data bits is 5 plus the value of `cfg_len` (00=5, 01=6, 10=7, 11=8). Each bit lasts 16 `tick16` pulses.
- R3: `cfg_parity[0]`=0 sends no parity bit. With bit 0 set, code 001 makes the total number of ones in data plus parity odd, and code 011 makes it even. Code 101 always sends 1 and code 111 always sends 0. The parity bit follows the last data bit.
- R4: With `cfg_two_stop`=0 the stop period is 16 ticks. With `cfg_two_stop`=1 it is 32 ticks, except that with 5-bit characters it is 24 ticks. The line is 1 for the whole stop period.
- R5: While `cfg_break` is 1, `txd` is 0. The frame in progress keeps its timing, and the line returns to normal as soon as break is cleared.
- R6: `hold_empty` is 1 exactly when the queue holds no byte. `tx_empty` is 1 exactly when the queue is empty and no frame is in flight.
- R7: The queue stores 16 bytes in order. `wr_ready` is 0 while it is full, and a byte offered then is not stored and is never sent.
- R8: A `fifo_flush` pulse discards every queued byte from the next cycle on. A frame already in flight still completes.
- R9: A frame starts only when a byte is queued. If a byte is waiting when a stop period ends, the next start bit follows in the very next cycle.
- R10: The length, parity and stop settings in use for a frame are the values present in the cycle that frame was started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit |
| cfg_len | input | 2 | Character length code, 5 + value bits |
| cfg_two_stop | input | 1 | Long stop period select |
| cfg_parity | input | 3 | Parity mode code |
| cfg_break | input | 1 | Force the line low |
| wr_valid | input | 1 | Write byte offered |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Queue can accept a byte |
| fifo_flush | input | 1 | Discard all queued bytes |
| txd | output | 1 | Serial line |
| hold_empty | output | 1 | Queue empty |
| tx_empty | output | 1 | Queue empty and serializer idle |

## Verification
The bench builds the block with its default parameters: a 16-entry queue and 16 ticks per bit. With these values the sweep can cover all 64 combinations of character length, stop select and parity code, and for each one it checks every bit and the exact frame length in cycles. The small queue depth lets the bench fill the queue, hit back-pressure, discard bytes and check back-to-back spacing within a short run. A tick divided by four shows that the timing follows the enable pulse and not the clock.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int unsigned CHAR_MAX_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic       two_stop;
    logic [2:0] parity;
  } frame_cfg_t;

  function automatic logic [3:0] char_bits(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  // mode[0]: parity on, mode[1]: even (or stick 0), mode[2]: stick
  function automatic logic par_value(input logic [CHAR_MAX_W-1:0] d,
                                     input logic [1:0] len,
                                     input logic [2:0] mode);
    logic [CHAR_MAX_W-1:0] mask;
    mask = 8'hFF >> (2'd3 - len);
    if (mode[2]) return !mode[1];
    if (mode[1]) return ^(d & mask);
    return ~^(d & mask);
  endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push_valid,
  input  logic [W-1:0] push_data,
  output logic         push_ready,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty      = (count == '0);
  assign push_ready = (count != CW'(DEPTH));
  assign do_push    = push_valid && push_ready && !flush;
  assign do_pop     = pop && !empty && !flush;
  assign pop_data   = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
  import uart_tx_pkg::*;
#(
  parameter int TPB = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  have_data,
  input  logic [CHAR_MAX_W-1:0] data,
  input  frame_cfg_t            cfg,
  output logic                  pop,
  output logic                  line,
  output logic                  idle
);
  localparam int CW        = $clog2(2 * TPB + 1);
  localparam int STOP_ONE  = TPB;
  localparam int STOP_HALF = TPB + TPB / 2;
  localparam int STOP_TWO  = 2 * TPB;

  tx_state_e             state;
  frame_cfg_t            fcfg;
  logic [CW-1:0]         cnt;
  logic [CW-1:0]         stop_len;
  logic [2:0]            bit_idx;
  logic [CHAR_MAX_W-1:0] shreg;
  logic                  par_bit;
  logic                  bit_end, stop_end, last_data;

  always_comb begin
    if (!fcfg.two_stop)        stop_len = CW'(STOP_ONE);
    else if (fcfg.len == 2'b0) stop_len = CW'(STOP_HALF);
    else                       stop_len = CW'(STOP_TWO);
  end

  assign bit_end   = tick && (cnt == CW'(TPB - 1));
  assign stop_end  = tick && (cnt == stop_len - 1'b1);
  assign last_data = ({1'b0, bit_idx} == char_bits(fcfg.len) - 4'd1);
  assign pop       = have_data && ((state == ST_IDLE) || ((state == ST_STOP) && stop_end));
  assign idle      = (state == ST_IDLE);

  always_comb begin
    unique case (state)
      ST_START: line = 1'b0;
      ST_DATA:  line = shreg[0];
      ST_PAR:   line = par_bit;
      default:  line = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      fcfg    <= '0;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
    end else if (pop) begin
      state   <= ST_START;
      fcfg    <= cfg;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= data;
      par_bit <= par_value(data, cfg.len, cfg.parity);
    end else begin
      unique case (state)
        ST_START: begin
          if (bit_end) begin
            cnt   <= '0;
            state <= ST_DATA;
          end else if (tick) cnt <= cnt + 1'b1;
        end
        ST_DATA: begin
          if (bit_end) begin
            cnt   <= '0;
            shreg <= shreg >> 1;
            if (last_data) state <= fcfg.parity[0] ? ST_PAR : ST_STOP;
            else           bit_idx <= bit_idx + 1'b1;
          end else if (tick) cnt <= cnt + 1'b1;
        end
        ST_PAR: begin
          if (bit_end) begin
            cnt   <= '0;
            state <= ST_STOP;
          end else if (tick) cnt <= cnt + 1'b1;
        end
        ST_STOP: begin
          if (stop_end) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else if (tick) cnt <= cnt + 1'b1;
        end
        default: cnt <= '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_line.sv
module uart_tx_line
  import uart_tx_pkg::*;
#(
  parameter int FIFO_DEPTH    = 16,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic [1:0] cfg_len,
  input  logic       cfg_two_stop,
  input  logic [2:0] cfg_parity,
  input  logic       cfg_break,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  output logic       wr_ready,
  input  logic       fifo_flush,
  output logic       txd,
  output logic       hold_empty,
  output logic       tx_empty
);
  logic                  q_empty, q_pop, ser_line, ser_idle;
  logic [CHAR_MAX_W-1:0] q_data;
  frame_cfg_t            cfg_now;

  assign cfg_now = '{len: cfg_len, two_stop: cfg_two_stop, parity: cfg_parity};

  uart_tx_fifo #(.W(CHAR_MAX_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (fifo_flush),
    .push_valid (wr_valid),
    .push_data  (wr_data),
    .push_ready (wr_ready),
    .pop        (q_pop),
    .pop_data   (q_data),
    .empty      (q_empty)
  );

  uart_tx_serializer #(.TPB(TICKS_PER_BIT)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick16),
    .have_data (!q_empty && !fifo_flush),
    .data      (q_data),
    .cfg       (cfg_now),
    .pop       (q_pop),
    .line      (ser_line),
    .idle      (ser_idle)
  );

  assign txd        = cfg_break ? 1'b0 : ser_line;
  assign hold_empty = q_empty;
  assign tx_empty   = q_empty && ser_idle;
endmodule

// File: rtl/uart_tx_line_sva.sv
module uart_tx_line_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       tick16,
  input logic [1:0] cfg_len,
  input logic       cfg_two_stop,
  input logic [2:0] cfg_parity,
  input logic       cfg_break,
  input logic       wr_valid,
  input logic [7:0] wr_data,
  input logic       wr_ready,
  input logic       fifo_flush,
  input logic       txd,
  input logic       hold_empty,
  input logic       tx_empty
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !cfg_break) |-> txd);

  assert_break_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_break |-> !txd);

  assert_status_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> hold_empty);

  assert_full_backpressure_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> !hold_empty);

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> hold_empty);

  assert_no_spontaneous_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !(wr_valid && wr_ready)) |=> tx_empty);
endmodule

bind uart_tx_line uart_tx_line_sva u_sva (.*);

// File: tb/uart_tx_line_bench.sv
module uart_tx_line_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_two_stop = 1'b0;
  logic [2:0] cfg_parity = 3'd0;
  logic       cfg_break = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       fifo_flush = 1'b0;
  logic       wr_ready, txd, hold_empty, tx_empty;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tick_period = 1;
  int tc = 0;

  uart_tx_line u_uart_tx_line (.*);

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    if (tick_period <= 1) tick16 = 1'b1;
    else begin
      tc = (tc + 1) % tick_period;
      tick16 = (tc == 0);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_par(input logic [7:0] d, input int n, input logic [2:0] m);
    int ones = 0;
    for (int i = 0; i < n; i++) ones += d[i];
    if (m[2]) return !m[1];
    if (m[1]) return (ones % 2) == 1;
    return (ones % 2) == 0;
  endfunction

  task automatic push_byte(input logic [7:0] d);
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_data = d;
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  // Waits for a start bit, samples mid-bit, measures cycles to tx_empty.
  task automatic measure(input logic [7:0] d, input int scale, input bit skip_bits, input string tag);
    int n = 5 + int'(cfg_len);
    int p = int'(cfg_parity[0]);
    int s = !cfg_two_stop ? 16 : (cfg_len == 2'd0 ? 24 : 32);
    logic [2:0] pm = cfg_parity;
    int f = 16 * (1 + n + p) + s;
    int k = 0;
    int guard = 0;
    logic [15:0] smp = '1;
    logic prev;
    logic [7:0] got = 8'h00;
    logic [7:0] mask = 8'hFF >> (8 - n);
    @(negedge clk);
    while (txd !== 1'b0 && guard < 200) begin @(negedge clk); guard++; end
    check(guard < 200, {"R9 start bit seen ", tag}, guard, 0);
    smp[0] = txd;
    prev = txd;
    while (!tx_empty && k < 5000) begin
      @(negedge clk);
      k++;
      for (int i = 0; i < 16; i++) if (k == scale * (16 * i + 8)) smp[i] = txd;
      if (!tx_empty) prev = txd;
    end
    if (!skip_bits) begin
      for (int i = 0; i < n; i++) got[i] = smp[1 + i];
      check(smp[0] == 1'b0, {"R2 start bit ", tag}, smp[0], 0);
      check(got == (d & mask), {"R2 data bits ", tag}, got, d & mask);
      if (p == 1) check(smp[1 + n] == exp_par(d, n, pm), {"R3 parity ", tag}, smp[1 + n], exp_par(d, n, pm));
      check(smp[1 + n + p] == 1'b1, {"R4 stop mid ", tag}, smp[1 + n + p], 1);
      check(prev == 1'b1, {"R4 stop last cycle ", tag}, prev, 1);
    end
    if (scale == 1) check(k == f, {"R4 frame length ", tag}, k, f);
    else check(k >= scale * f - scale && k <= scale * f + scale, {"R2 tick-paced length ", tag}, k, scale * f);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(txd == 1'b1, "R1 reset txd", txd, 1);
    check(hold_empty == 1'b1, "R1 reset hold_empty", hold_empty, 1);
    check(tx_empty == 1'b1, "R1 reset tx_empty", tx_empty, 1);
    check(wr_ready == 1'b1, "R1 reset wr_ready", wr_ready, 1);

    // Sweep all length / stop / parity codes
    for (int len = 0; len < 4; len++)
      for (int ts = 0; ts < 2; ts++)
        for (int par = 0; par < 8; par++) begin
          logic [7:0] d = 8'(8'h5A + len * 53 + ts * 29 + par * 17);
          @(posedge clk); #1;
          cfg_len = 2'(len); cfg_two_stop = 1'(ts); cfg_parity = 3'(par);
          push_byte(d);
          measure(d, 1, 1'b0, $sformatf("len%0d stop%0d par%0d", len, ts, par));
        end

    // Tick paced at one pulse in four cycles
    @(posedge clk); #1;
    cfg_len = 2'd3; cfg_two_stop = 1'b0; cfg_parity = 3'd0;
    tick_period = 4;
    push_byte(8'hC3);
    measure(8'hC3, 4, 1'b0, "slow tick");
    tick_period = 1;

    // Break while idle
    @(posedge clk); #1 cfg_break = 1'b1;
    @(negedge clk);
    check(txd == 1'b0, "R5 break idle low", txd, 0);
    @(posedge clk); #1 cfg_break = 1'b0;
    @(negedge clk);
    check(txd == 1'b1, "R5 break released high", txd, 1);

    // Break mid-frame plus config change mid-frame (R10): timing unchanged
    @(posedge clk); #1;
    cfg_len = 2'd3; cfg_two_stop = 1'b0; cfg_parity = 3'b011;
    push_byte(8'h96);
    fork
      measure(8'h96, 1, 1'b1, "break and cfg change R10");
      begin
        repeat (40) @(negedge clk);
        @(posedge clk); #1;
        cfg_break = 1'b1; cfg_two_stop = 1'b1; cfg_len = 2'd0; cfg_parity = 3'd0;
        repeat (3) @(negedge clk);
        check(txd == 1'b0, "R5 break mid-frame", txd, 0);
        @(posedge clk); #1 cfg_break = 1'b0;
      end
    join
    @(posedge clk); #1;
    cfg_len = 2'd3; cfg_two_stop = 1'b0; cfg_parity = 3'd0;

    // Flood: fill queue, back-pressure, back-to-back spacing
    begin
      logic [7:0] got [17];
      int st [17];
      fork
        begin
          for (int fr = 0; fr < 17; fr++) begin
            int g = 0;
            @(negedge clk);
            while (txd !== 1'b0 && g < 400) begin @(negedge clk); g++; end
            st[fr] = cyc;
            got[fr] = 8'h00;
            repeat (8) @(negedge clk);
            for (int b = 0; b < 8; b++) begin
              repeat (16) @(negedge clk);
              got[fr][b] = txd;
            end
            repeat (16) @(negedge clk);
            check(txd == 1'b1, $sformatf("R4 flood stop frame %0d", fr), txd, 1);
          end
        end
        begin
          for (int i = 0; i < 17; i++) begin
            @(posedge clk); #1;
            wr_valid = 1'b1; wr_data = 8'(8'h30 + i);
          end
          @(posedge clk); #1 wr_valid = 1'b0;
          @(negedge clk);
          check(wr_ready == 1'b0, "R7 full drops ready", wr_ready, 0);
          check(hold_empty == 1'b0, "R6 hold_empty while queued", hold_empty, 0);
          check(tx_empty == 1'b0, "R6 tx_empty while busy", tx_empty, 0);
          @(posedge clk); #1;
          wr_valid = 1'b1; wr_data = 8'hEE;
          repeat (3) @(posedge clk);
          #1 wr_valid = 1'b0;
        end
      join
      for (int fr = 0; fr < 17; fr++)
        check(got[fr] == 8'(8'h30 + fr), $sformatf("R7 order frame %0d", fr), got[fr], 8'h30 + fr);
      for (int fr = 1; fr < 17; fr++)
        check(st[fr] - st[fr - 1] == 160, $sformatf("R9 back-to-back spacing %0d", fr), st[fr] - st[fr - 1], 160);
      begin
        int g = 0;
        while (!tx_empty && g < 400) begin @(negedge clk); g++; end
        check(tx_empty == 1'b1, "R6 tx_empty after drain", tx_empty, 1);
        g = 0;
        repeat (300) begin @(negedge clk); if (txd != 1'b1) g++; end
        check(g == 0, "R7 dropped byte never sent", g, 0);
      end
    end

    // Flush: queued bytes discarded, in-flight frame completes
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_data = 8'h11;
    repeat (4) @(posedge clk);
    #1 wr_valid = 1'b0;
    repeat (20) @(posedge clk);
    #1 fifo_flush = 1'b1;
    @(posedge clk); #1 fifo_flush = 1'b0;
    @(negedge clk);
    check(hold_empty == 1'b1, "R8 flush empties queue", hold_empty, 1);
    check(tx_empty == 1'b0, "R8 in-flight frame continues", tx_empty, 0);
    begin
      int g = 0;
      int lows = 0;
      while (!tx_empty && g < 400) begin @(negedge clk); g++; end
      check(g > 100 && g < 200, "R8 frame completes after flush", g, 140);
      repeat (400) begin @(negedge clk); if (txd != 1'b1) lows++; end
      check(lows == 0, "R8 no frame after flush", lows, 0);
      check(tx_empty == 1'b1, "R1 idle after flush", tx_empty, 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule